// File: doc/BRIEF.md
# Frame-Indexed Multi-Space DMA Channel

This block is a single direct-memory-access channel that copies words from one address space to another without processor help. Each source and destination can independently be program, data or I/O space. A transfer block is built from frames, and each frame is a number of elements. After an element the addresses move by an element step. After the last element of a frame they move by a frame step instead. The block can run freely, or it can move one element for each rising edge of a chosen sync line.

Software sets the channel up through a one-cycle register write port (`cfg_we`, `cfg_addr`, `cfg_wdata`). Register codes:

| Code | Register |
|------|----------|
| 0 | control: bits [1:0] source space, bits [3:2] destination space, bit 4 auto-reload, bit 5 enable |
| 1 | trigger: bits [7:0] frame count, bit 8 double word, bits [11:9] sync select |
| 2 | source address |
| 3 | destination address |
| 4 | element count |
| 5 | element step |
| 6 | frame step |
| 7 | source reload |
| 8 | destination reload |
| 9 | element count reload |
| 10 | frame count reload |

The memory side is a request/grant port. Every element performs a read phase and then a write phase. At the end of a block the channel raises `done` for one cycle. With auto-reload set, it re-arms itself from the reload registers.

Top module: `dma_chan`

## Requirements
- R1: While `rst` is high, and afterwards until the control enable bit is written, `mem_req`, `done` and `active` are all 0.
- R2: Each element issues a read (`mem_we`=0) on the source space and then a write (`mem_we`=1) on the destination space. The write carries the word returned by the read. Space codes on `mem_space` are 0 for program, 1 for data and 2 for I/O, taken from control bits [1:0] for the source and [3:2] for the destination.
- R3: Inside a frame, both addresses advance by the element step (register 5) after every element that is not the frame's last, wrapping modulo 2^AW.
- R4: After the last element of a frame, both addresses advance by the frame step (register 6) instead. The element counter reloads from register 9 and the frame counter decrements.
- R5: After the final element of the final frame, `done` is high for exactly one cycle. If auto-reload (control bit 4) is clear, `active` drops in that same cycle.
- R6: With auto-reload set, block end reloads source, destination, element count and frame count from registers 7, 8, 9 and 10. `active` stays high, and the next block starts from the reloaded addresses.
- R7: A nonzero sync select n (trigger bits [11:9]) moves one element per rising edge of `sync_in[n-1]`. A level held high moves only one element. Without an edge, or on an edge of any other line, nothing moves.
- R8: With sync select 0, elements run back to back. Each element takes one idle cycle plus its read and write phases.
- R9: A request holds its address, space, direction and write data stable until a cycle in which `mem_gnt` is high. Read data is captured in that grant cycle.
- R10: With trigger bit 8 set, each element performs two read/write pairs, at the current address and at that address plus one. The steps apply to the first address.
- R11: An element count or frame count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register code |
| cfg_wdata | input | AW | Register write data |
| sync_in | input | NSYNC | Sync event lines |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write phase, 0 for read phase |
| mem_space | output | 2 | Target space code |
| mem_addr | output | AW | Target address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with grant |
| mem_gnt | input | 1 | Grant, completes the current phase |
| done | output | 1 | One-cycle block-end pulse |
| active | output | 1 | Channel enabled |

## Verification
The assertions check the handshake rules on every cycle: a pending request stays stable, a granted read is followed at once by a write, no request appears without `active`, and `done` lasts one cycle and never overlaps a request. The actual address sequences can only be shown by the bench scenarios, which compare every logged write with a model. These cover element and frame stepping, wrap-around, double-word pairs, zero counts, auto-reload re-arming, sync gating by edge and by line, and the back-to-back cycle cost under wait states.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_RSVD = 2'd3
    } space_t;

    typedef enum logic [3:0] {
        RG_CTRL   = 4'd0,
        RG_TRIG   = 4'd1,
        RG_SRC    = 4'd2,
        RG_DST    = 4'd3,
        RG_CNT    = 4'd4,
        RG_ESTEP  = 4'd5,
        RG_FSTEP  = 4'd6,
        RG_RSRC   = 4'd7,
        RG_RDST   = 4'd8,
        RG_RCNT   = 4'd9,
        RG_RFRM   = 4'd10
    } regsel_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_t;

    // control register bit positions
    localparam int CTRL_AUTO = 4;
    localparam int CTRL_EN   = 5;

endpackage

// File: rtl/dmach_sync.sv
module dmach_sync #(
    parameter int NSYNC = 4,
    parameter int SELW  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             take,
    input  logic [NSYNC-1:0] sync_in,
    input  logic [SELW-1:0]  sel,
    output logic             go
);
    logic [NSYNC-1:0] prev;
    logic [NSYNC-1:0] rise;
    logic             hit;
    logic             pend;

    generate
        for (genvar g = 0; g < NSYNC; g++) begin : g_edge
            assign rise[g] = sync_in[g] & ~prev[g];
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NSYNC; i++) begin
            if (sel == SELW'(i + 1)) hit = rise[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            pend <= 1'b0;
        end else begin
            prev <= sync_in;
            pend <= arm & (hit | (pend & ~take));
        end
    end

    assign go = (sel == '0) | pend;
endmodule

// File: rtl/dmach_ctx.sv
module dmach_ctx
    import dmach_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 8,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [3:0]      cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            step,
    output logic [AW-1:0]   src,
    output logic [AW-1:0]   dst,
    output logic            dbl,
    output logic [SELW-1:0] sel,
    output space_t          ssp,
    output space_t          dsp,
    output logic            active,
    output logic            done
);
    logic [CW-1:0] ecnt, fcnt, rcnt, rfrm;
    logic [AW-1:0] rsrc, rdst, estep, fstep;
    logic          autold;
    logic          last_e, last_f;

    assign last_e = (ecnt <= CW'(1));
    assign last_f = (fcnt <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            src <= '0; dst <= '0; ecnt <= '0; fcnt <= '0;
            rsrc <= '0; rdst <= '0; rcnt <= '0; rfrm <= '0;
            estep <= '0; fstep <= '0;
            dbl <= 1'b0; sel <= '0; autold <= 1'b0; active <= 1'b0;
            ssp <= SP_PROG; dsp <= SP_PROG;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (step) begin
                if (last_e) begin
                    src  <= src + fstep;
                    dst  <= dst + fstep;
                    ecnt <= rcnt;
                    if (last_f) begin
                        done <= 1'b1;
                        if (autold) begin
                            src  <= rsrc;
                            dst  <= rdst;
                            fcnt <= rfrm;
                        end else begin
                            active <= 1'b0;
                        end
                    end else begin
                        fcnt <= fcnt - CW'(1);
                    end
                end else begin
                    src  <= src + estep;
                    dst  <= dst + estep;
                    ecnt <= ecnt - CW'(1);
                end
            end
            if (cfg_we) begin
                case (cfg_addr)
                    RG_CTRL: begin
                        ssp    <= space_t'(cfg_wdata[1:0]);
                        dsp    <= space_t'(cfg_wdata[3:2]);
                        autold <= cfg_wdata[CTRL_AUTO];
                        active <= cfg_wdata[CTRL_EN];
                    end
                    RG_TRIG: begin
                        fcnt <= cfg_wdata[CW-1:0];
                        dbl  <= cfg_wdata[CW];
                        sel  <= cfg_wdata[CW+1 +: SELW];
                    end
                    RG_SRC:   src   <= cfg_wdata;
                    RG_DST:   dst   <= cfg_wdata;
                    RG_CNT:   ecnt  <= cfg_wdata[CW-1:0];
                    RG_ESTEP: estep <= cfg_wdata;
                    RG_FSTEP: fstep <= cfg_wdata;
                    RG_RSRC:  rsrc  <= cfg_wdata;
                    RG_RDST:  rdst  <= cfg_wdata;
                    RG_RCNT:  rcnt  <= cfg_wdata[CW-1:0];
                    RG_RFRM:  rfrm  <= cfg_wdata[CW-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          go,
    input  logic          dbl,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  space_t        ssp,
    input  space_t        dsp,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [1:0]    mem_space,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          take,
    output logic          step
);
    phase_t        ph;
    logic          half;
    logic [DW-1:0] hold;
    logic [AW-1:0] offs;

    assign offs = {{(AW-1){1'b0}}, half};

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_space = ssp;
        mem_addr  = src + offs;
        mem_wdata = hold;
        take      = 1'b0;
        step      = 1'b0;
        case (ph)
            PH_IDLE: take = active & go;
            PH_RD:   mem_req = 1'b1;
            PH_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_space = dsp;
                mem_addr  = dst + offs;
                step      = mem_gnt & ~(dbl & ~half);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            half <= 1'b0;
            hold <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (take) begin
                    ph   <= PH_RD;
                    half <= 1'b0;
                end
                PH_RD: if (mem_gnt) begin
                    hold <= mem_rdata;
                    ph   <= PH_WR;
                end
                PH_WR: if (mem_gnt) begin
                    if (dbl && !half) begin
                        half <= 1'b1;
                        ph   <= PH_RD;
                    end else begin
                        ph <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dmach_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CW    = 8,
    parameter int NSYNC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_addr,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic [NSYNC-1:0] sync_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_space,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_gnt,
    output logic             done,
    output logic             active
);
    localparam int SELW = $clog2(NSYNC + 1);

    logic [AW-1:0]   src, dst;
    logic            dbl, go, take, step;
    logic [SELW-1:0] sel;
    space_t          ssp, dsp;

    dmach_ctx #(.AW(AW), .CW(CW), .SELW(SELW)) u_ctx (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .step(step),
        .src(src), .dst(dst), .dbl(dbl), .sel(sel),
        .ssp(ssp), .dsp(dsp), .active(active), .done(done)
    );

    dmach_sync #(.NSYNC(NSYNC), .SELW(SELW)) u_sync (
        .clk(clk), .rst(rst), .arm(active), .take(take),
        .sync_in(sync_in), .sel(sel), .go(go)
    );

    dmach_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst(rst), .active(active), .go(go), .dbl(dbl),
        .src(src), .dst(dst), .ssp(ssp), .dsp(dsp),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .take(take), .step(step)
    );
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          mem_we,
    input logic [1:0]    mem_space,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          done,
    input logic          active
);
    // R9: an ungranted request holds still
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_space) && $stable(mem_wdata)));

    // R2: a granted read is followed at once by the write phase
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && !mem_we) |=> (mem_req && mem_we));

    // R1: no traffic from a disabled channel
    a_r1_req_needs_active: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> active);

    // R5: block-end flag is a single-cycle pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: block end never coincides with a bus phase
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);
endmodule

bind dma_chan dmach_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_space(mem_space), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .active(active)
);

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
    localparam int AW = 16, DW = 16, CW = 8, NS = 4;

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [7:0]  ecnt;
        logic [7:0]  fcnt;
        logic [15:0] estep;
        logic [15:0] fstep;
        logic [1:0]  ss;
        logic [1:0]  ds;
        logic        dbl;
        logic [1:0]  gw;
        logic [7:0]  nwr;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{16'h0100, 16'h0200, 8'd3, 8'd2, 16'd1, 16'h0010, 2'd0, 2'd1, 1'b0, 2'd0, 8'd6},
        '{16'h1000, 16'h2000, 8'd2, 8'd3, 16'd2, 16'hFFFD, 2'd2, 2'd0, 1'b0, 2'd2, 8'd6},
        '{16'hFFFE, 16'h0040, 8'd4, 8'd1, 16'd1, 16'd0,    2'd1, 2'd2, 1'b0, 2'd1, 8'd4},
        '{16'h0300, 16'h0400, 8'd2, 8'd2, 16'd2, 16'd4,    2'd1, 2'd1, 1'b1, 2'd0, 8'd8},
        '{16'h0500, 16'h0600, 8'd0, 8'd0, 16'd1, 16'd1,    2'd0, 2'd2, 1'b0, 2'd1, 8'd1},
        '{16'h0700, 16'h0800, 8'd1, 8'd4, 16'd5, 16'd3,    2'd2, 2'd1, 1'b0, 2'd0, 8'd4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [NS-1:0] sync_in = '0;
    logic          mem_req, mem_we, done, active;
    logic [1:0]    mem_space;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_gnt = 1'b0;

    always #10 clk = ~clk;

    dma_chan #(.AW(AW), .DW(DW), .CW(CW), .NSYNC(NS)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sync_in(sync_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .done(done), .active(active)
    );

    int checks = 0;
    int errors = 0;
    int nlog = 0, ndone = 0, nact = 0, wcnt = 0;
    logic [1:0]  gwait = 2'd0;
    logic [1:0]  lg_sp [256];
    logic [15:0] lg_a  [256];
    logic [15:0] lg_d  [256];
    logic [1:0]  ex_sp [64];
    logic [15:0] ex_a  [64];
    logic [15:0] ex_d  [64];

    function automatic logic [15:0] memfn(input logic [1:0] sp, input logic [15:0] a);
        return (a * 16'd5) ^ {sp, 4'h0, sp, 8'h5A};
    endfunction

    // memory responder with programmable wait states, logs every write
    always @(negedge clk) begin
        if (rst) begin
            mem_gnt <= 1'b0;
            wcnt    <= 0;
        end else begin
            if (done)   ndone <= ndone + 1;
            if (active) nact  <= nact + 1;
            if (mem_req) begin
                if (wcnt >= int'(gwait)) begin
                    mem_gnt   <= 1'b1;
                    wcnt      <= 0;
                    mem_rdata <= memfn(mem_space, mem_addr);
                    if (mem_we && nlog < 256) begin
                        lg_sp[nlog] <= mem_space;
                        lg_a[nlog]  <= mem_addr;
                        lg_d[nlog]  <= mem_wdata;
                        nlog        <= nlog + 1;
                    end
                end else begin
                    mem_gnt <= 1'b0;
                    wcnt    <= wcnt + 1;
                end
            end else begin
                mem_gnt <= 1'b0;
                wcnt    <= 0;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        tick();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic prog(input logic [15:0] s, input logic [15:0] d, input logic [7:0] ec,
                        input logic [7:0] fc, input logic [15:0] es, input logic [15:0] fs,
                        input logic [1:0] ss, input logic [1:0] ds, input logic dbl,
                        input logic [2:0] sel, input logic auto);
        wr(4'd7, s);  wr(4'd8, d);  wr(4'd9, {8'h00, ec}); wr(4'd10, {8'h00, fc});
        wr(4'd2, s);  wr(4'd3, d);  wr(4'd4, {8'h00, ec});
        wr(4'd5, es); wr(4'd6, fs);
        wr(4'd1, {4'h0, sel, dbl, fc});
        wr(4'd0, {10'd0, 1'b1, auto, ds, ss});
    endtask

    task automatic pulse0();
        sync_in[0] = 1'b1;
        repeat (8) tick();
        sync_in[0] = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lbase, dbase, abase;
        repeat (3) tick();
        chk(mem_req == 1'b0, "R1", int'(mem_req), 0, "mem_req in reset");
        chk(done == 1'b0,    "R1", int'(done),    0, "done in reset");
        chk(active == 1'b0,  "R1", int'(active),  0, "active in reset");
        rst = 1'b0;
        repeat (3) tick();
        chk(mem_req == 1'b0 && active == 1'b0, "R1", int'(mem_req), 0, "idle after reset");

        // table-driven free-running blocks
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            int ne, nf, nh, nexp, t;
            logic [15:0] s, d;
            string tag;
            v = VEC[i];
            gwait = v.gw;
            ne = (v.ecnt == 0) ? 1 : int'(v.ecnt);
            nf = (v.fcnt == 0) ? 1 : int'(v.fcnt);
            nh = v.dbl ? 2 : 1;
            tag = v.dbl ? "R10" : ((v.ecnt == 0) ? "R11" : "R3 R4");
            s = v.src; d = v.dst; nexp = 0;
            for (int f = 0; f < nf; f++) begin
                for (int e = 0; e < ne; e++) begin
                    for (int h = 0; h < nh; h++) begin
                        ex_sp[nexp] = v.ds;
                        ex_a[nexp]  = d + 16'(h);
                        ex_d[nexp]  = memfn(v.ss, s + 16'(h));
                        nexp++;
                    end
                    if (e == ne - 1) begin s = s + v.fstep; d = d + v.fstep; end
                    else begin s = s + v.estep; d = d + v.estep; end
                end
            end
            chk(nexp == int'(v.nwr), "R11", nexp, int'(v.nwr), "model write count");
            lbase = nlog; dbase = ndone; abase = nact;
            prog(v.src, v.dst, v.ecnt, v.fcnt, v.estep, v.fstep, v.ss, v.ds, v.dbl, 3'd0, 1'b0);
            t = 0;
            while (ndone == dbase && t < 3000) begin tick(); t++; end
            repeat (2) tick();
            chk(ndone - dbase == 1, "R5", ndone - dbase, 1, "done pulses");
            chk(active == 1'b0, "R5", int'(active), 0, "active after block");
            chk(nlog - lbase == nexp, tag, nlog - lbase, nexp, "write count");
            chk(nact - abase == ne * nf * (1 + 2 * nh * (int'(v.gw) + 1)), "R8",
                nact - abase, ne * nf * (1 + 2 * nh * (int'(v.gw) + 1)), "active cycles");
            for (int k = 0; k < nexp && k < 64; k++) begin
                chk(lg_a[lbase + k] == ex_a[k], tag, int'(lg_a[lbase + k]), int'(ex_a[k]), "write address");
                chk(lg_sp[lbase + k] == ex_sp[k], "R2", int'(lg_sp[lbase + k]), int'(ex_sp[k]), "write space");
                chk(lg_d[lbase + k] == ex_d[k], "R9", int'(lg_d[lbase + k]), int'(ex_d[k]), "write data");
            end
        end

        // sync-gated block with auto-reload
        gwait = 2'd0;
        lbase = nlog; dbase = ndone;
        prog(16'h0A00, 16'h0B00, 8'd2, 8'd1, 16'd1, 16'd0, 2'd0, 2'd1, 1'b0, 3'd1, 1'b1);
        repeat (10) tick();
        chk(nlog == lbase, "R7", nlog - lbase, 0, "no edge, no move");
        sync_in[1] = 1'b1;
        repeat (6) tick();
        sync_in[1] = 1'b0;
        repeat (4) tick();
        chk(nlog == lbase, "R7", nlog - lbase, 0, "unselected line ignored");
        pulse0();
        chk(nlog - lbase == 1, "R7", nlog - lbase, 1, "one element per held edge");
        chk(lg_a[lbase] == 16'h0B00, "R7", int'(lg_a[lbase]), 16'h0B00, "first sync address");
        pulse0();
        chk(nlog - lbase == 2, "R7", nlog - lbase, 2, "second edge");
        chk(lg_a[lbase + 1] == 16'h0B01, "R3", int'(lg_a[lbase + 1]), 16'h0B01, "stepped address");
        chk(ndone - dbase == 1, "R5", ndone - dbase, 1, "block end in sync mode");
        chk(active == 1'b1, "R6", int'(active), 1, "stays active with reload");
        pulse0();
        chk(lg_a[lbase + 2] == 16'h0B00, "R6", int'(lg_a[lbase + 2]), 16'h0B00, "reloaded destination");
        chk(lg_d[lbase + 2] == memfn(2'd0, 16'h0A00), "R6", int'(lg_d[lbase + 2]),
            int'(memfn(2'd0, 16'h0A00)), "reloaded source");
        pulse0();
        chk(ndone - dbase == 2, "R6", ndone - dbase, 2, "second block end");
        chk(nlog - lbase == 4, "R6", nlog - lbase, 4, "writes over two blocks");
        wr(4'd0, 16'h0004);
        tick();
        chk(active == 1'b0, "R5", int'(active), 0, "disabled by control write");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule